// File: doc/BRIEF.md
# Guarded System Clock Ratio Controller

This block sits on a simple peripheral register bus and owns two critical control registers: the clock-ratio register, which picks the system clock rate, and an 8-bit flash-mode register. Neither can be changed by a single stray store. Software first writes any byte to a write-only unlock register. The very next bus write may then update one of the two guarded registers. A guarded store that arrives without a pending unlock is dropped, and it sets a sticky error bit that software can read back and clear.

The block runs entirely on the 10x PLL clock, which also clocks the register bus. From that clock it produces a system-clock enable strobe. The strobe is high once per system-clock period, with one period lasting 10, 4, 2 or 1 PLL cycles, for system rates of 1x, 2.5x, 5x or 10x the reference. A downstream clock gate consumes the strobe. A changed ratio is applied only at the common boundary of all four candidate periods, so no period is ever cut short.

Top module: `prot_clkctl_unit`

## Requirements
- R1: After reset the clock-ratio register reads 0 and the active ratio is 2'b00 (1x, one strobe every 10 PLL cycles). The flash-mode register reads 0 and the status error bit reads 0.
- R2: A write of any byte to the unlock register at 0xFFFFF800 arms the unlock. A read of that address returns 0.
- R3: An armed unlock followed by a write to the clock-ratio register at 0xFFFFF822 stores wdata[1:0], which reads back at that address in bits [1:0]. The error bit is left unchanged.
- R4: A write to a guarded register (0xFFFFF822 or 0xFFFFF824) with no armed unlock is ignored, and it sets the error bit, which is bit 0 of the status register at 0xFFFFF802.
- R5: The unlock is consumed by the very next bus write, whatever its address. After an unlock followed by a write elsewhere, a guarded write is ignored and sets the error bit. A second unlock write re-arms.
- R6: The error bit is sticky. It clears only on reset or on a status-register write with wdata[0]=0. A status write with wdata[0]=1 leaves it unchanged.
- R7: Ratio encoding sets the strobe spacing in PLL cycles: 2'b00 gives 10 (1x), 2'b01 gives 4 (2.5x), 2'b10 gives 2 (5x), and 2'b11 gives 1 (10x, strobe always high).
- R8: A new ratio becomes active only at the end of the 20-cycle common frame. Every strobe interval around a change equals either the old spacing or the new spacing, and no old spacing follows a new one.
- R9: The flash-mode register at 0xFFFFF824 holds 8 bits. It is written only under an armed unlock and drives the flash_mode output.
- R10: Reads of unmapped addresses, and any read with rd_en low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | 10x PLL clock; also the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 32 | Bus byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| flash_mode | output | 8 | Flash-mode register contents |
| ratio_active | output | 2 | Ratio currently applied to the strobe |
| sys_en | output | 1 | System-clock enable strobe |

## Verification
The guard is tried with three write patterns: unlock then guarded write, guarded write alone, and unlock then an unrelated write then a guarded write. Together they separate a correct one-shot unlock from a missing guard and from an unlock that persists too long. A double-unlock pattern shows that a command write re-arms rather than simply clearing. The divider is swept over all sixteen old/new ratio pairs. Every strobe interval across each switch is measured, which tells a switch taken at the frame boundary apart from one taken mid-period, and tells a wrong encoding apart from a right one.

// File: rtl/ckp_pkg.sv
package ckp_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_UNLOCK = 32'hFFFF_F800;
    localparam logic [ADDR_W-1:0] A_STATUS = 32'hFFFF_F802;
    localparam logic [ADDR_W-1:0] A_RATIO  = 32'hFFFF_F822;
    localparam logic [ADDR_W-1:0] A_FLASH  = 32'hFFFF_F824;

    typedef enum logic [1:0] {
        RATIO_1X   = 2'b00,
        RATIO_2P5X = 2'b01,
        RATIO_5X   = 2'b10,
        RATIO_10X  = 2'b11
    } ratio_e;

    localparam int DIV_1X   = 10;
    localparam int DIV_2P5X = 4;
    localparam int DIV_5X   = 2;
    localparam int DIV_10X  = 1;

    function automatic int unsigned div_of(ratio_e r);
        case (r)
            RATIO_1X:   return DIV_1X;
            RATIO_2P5X: return DIV_2P5X;
            RATIO_5X:   return DIV_5X;
            default:    return DIV_10X;
        endcase
    endfunction

    function automatic int unsigned gcd(int unsigned a, int unsigned b);
        int unsigned x = a;
        int unsigned y = b;
        while (y != 0) begin
            int unsigned t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int unsigned lcm(int unsigned a, int unsigned b);
        return (a / gcd(a, b)) * b;
    endfunction

    // Common frame: every candidate period starts together at phase 0.
    localparam int FRAME = lcm(lcm(DIV_1X, DIV_2P5X), lcm(DIV_5X, DIV_10X));
    localparam int PH_W  = $clog2(FRAME);

    typedef struct packed {
        logic ratio_we;
        logic flash_we;
        logic armed;
        logic err;
    } guard_t;
endpackage

// File: rtl/ckp_guard.sv
module ckp_guard
    import ckp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wbit0,
    output guard_t            g
);
    logic armed_q, err_q;
    logic hit_unlock, hit_status, hit_guarded;

    always_comb begin
        hit_unlock  = (addr == A_UNLOCK);
        hit_status  = (addr == A_STATUS);
        hit_guarded = (addr == A_RATIO) || (addr == A_FLASH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (wr_en) begin
            // Any write consumes the unlock; an unlock write re-arms it.
            armed_q <= hit_unlock;
            if (hit_guarded && !armed_q)
                err_q <= 1'b1;
            else if (hit_status && !wbit0)
                err_q <= 1'b0;
        end
    end

    always_comb begin
        g.ratio_we = wr_en && armed_q && (addr == A_RATIO);
        g.flash_we = wr_en && armed_q && (addr == A_FLASH);
        g.armed    = armed_q;
        g.err      = err_q;
    end
endmodule

// File: rtl/ckp_divider.sv
module ckp_divider
    import ckp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ratio_e          req_ratio,
    output ratio_e          act_ratio,
    output logic [PH_W-1:0] phase,
    output logic            sys_en
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME - 1);

    logic [PH_W-1:0] phase_q;
    ratio_e          act_q;
    int unsigned     ph_int;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            act_q   <= RATIO_1X;
        end else begin
            if (phase_q == PH_LAST) begin
                phase_q <= '0;
                act_q   <= req_ratio;   // switch only at the common boundary
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    always_comb begin
        ph_int = 32'(phase_q);
        sys_en = (ph_int % div_of(act_q)) == 0;
    end

    assign act_ratio = act_q;
    assign phase     = phase_q;
endmodule

// File: rtl/prot_clkctl_unit.sv
module prot_clkctl_unit
    import ckp_pkg::*;
(
    input  logic              pll_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] flash_mode,
    output logic [1:0]        ratio_active,
    output logic              sys_en
);
    guard_t            g;
    ratio_e            ratio_q;
    ratio_e            act;
    logic [DATA_W-1:0] flash_q;
    logic [PH_W-1:0]   phase;

    ckp_guard i_guard (
        .clk   (pll_clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wbit0 (wdata[0]),
        .g     (g)
    );

    always_ff @(posedge pll_clk) begin
        if (rst) begin
            ratio_q <= RATIO_1X;
            flash_q <= '0;
        end else begin
            if (g.ratio_we) ratio_q <= ratio_e'(wdata[1:0]);
            if (g.flash_we) flash_q <= wdata;
        end
    end

    ckp_divider i_div (
        .clk       (pll_clk),
        .rst       (rst),
        .req_ratio (ratio_q),
        .act_ratio (act),
        .phase     (phase),
        .sys_en    (sys_en)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_RATIO:  rdata = {{(DATA_W-2){1'b0}}, ratio_q};
                A_FLASH:  rdata = flash_q;
                A_STATUS: rdata = {{(DATA_W-1){1'b0}}, g.err};
                default:  rdata = '0;   // unlock register reads as zero
            endcase
        end
    end

    assign flash_mode   = flash_q;
    assign ratio_active = act;
endmodule

// File: rtl/ckp_checker.sv
module ckp_checker
    import ckp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        ratio_active,
    input logic              sys_en,
    input logic              armed,
    input logic              err,
    input logic [1:0]        ratio_reg,
    input logic [PH_W-1:0]   phase
);
    // R1: reset puts the active ratio at 1x
    p_reset_ratio_r1: assert property (@(posedge clk) rst |=> ratio_active == 2'b00);

    // R2: an unlock write arms; reads of it are zero
    p_unlock_arms_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == A_UNLOCK |=> armed);
    p_unlock_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr == A_UNLOCK |-> rdata == '0);

    // R4: an unguarded protected write is dropped and flags an error
    p_locked_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == A_RATIO && !armed |=> $stable(ratio_reg) && err);

    // R5: any other write consumes the unlock
    p_unlock_consumed_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr != A_UNLOCK |=> !armed);

    // R6: the error bit stays set unless cleared through the status register
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err && !(wr_en && addr == A_STATUS && !wdata[0]) |=> err);

    // R7: the 10x ratio enables every cycle
    p_full_rate_r7: assert property (@(posedge clk) disable iff (rst)
        ratio_active == 2'b11 |-> sys_en);

    // R8: the active ratio moves only at the frame end
    p_switch_at_frame_r8: assert property (@(posedge clk) disable iff (rst)
        phase != PH_W'(FRAME - 1) |=> $stable(ratio_active));
endmodule

bind prot_clkctl_unit ckp_checker i_chk (
    .clk          (pll_clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .ratio_active (ratio_active),
    .sys_en       (sys_en),
    .armed        (g.armed),
    .err          (g.err),
    .ratio_reg    (ratio_q),
    .phase        (phase)
);

// File: tb/test_prot_clkctl_unit.sv
`timescale 1ns/1ps
module test_prot_clkctl_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata, flash_mode;
    logic [1:0]  ratio_active;
    logic        sys_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [31:0] UNL = 32'hFFFF_F800, STA = 32'hFFFF_F802,
                            RAT = 32'hFFFF_F822, FLS = 32'hFFFF_F824;

    always #4 clk = ~clk;

    prot_clkctl_unit i_prot_clkctl_unit (
        .pll_clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .flash_mode(flash_mode),
        .ratio_active(ratio_active), .sys_en(sys_en)
    );

    function automatic int spacing(int sel);
        case (sel)
            0: return 10;
            1: return 4;
            2: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0;
    endtask

    task automatic rd(logic [31:0] a, output int d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = int'(rdata);
        rd_en = 1'b0; addr = '0;
    endtask

    // Measure one full strobe interval in PLL cycles.
    task automatic one_gap(output int g);
        int n = 0;
        do @(negedge clk); while (!sys_en);
        do begin @(negedge clk); n++; end while (!sys_en);
        g = n;
    endtask

    task automatic transition(int from, int to);
        int gap = 0;
        int last = 0;
        bit started = 0;
        bit ok = 1;
        bit saw_new = 0;
        wr(UNL, 8'h00); wr(RAT, 8'(from));
        repeat (45) @(negedge clk);
        wr(UNL, 8'hC3); wr(RAT, 8'(to));
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            gap++;
            if (sys_en) begin
                if (started) begin
                    if (gap != spacing(from) && gap != spacing(to)) ok = 0;
                    if (saw_new && gap != spacing(to)) ok = 0;
                    if (gap == spacing(to) && spacing(to) != spacing(from)) saw_new = 1;
                    last = gap;
                end
                started = 1;
                gap = 0;
            end
        end
        check($sformatf("R8 no runt %0d->%0d", from, to), int'(ok), 1);
        check($sformatf("R7 spacing sel %0d", to), last, spacing(to));
        check("R7 ratio_active", int'(ratio_active), to);
    endtask

    initial begin
        int d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 ratio_active", int'(ratio_active), 0);
        rd(RAT, d); check("R1 ratio reg", d, 0);
        rd(FLS, d); check("R1 flash reg", d, 0);
        rd(STA, d); check("R1 error bit", d, 0);
        one_gap(d); check("R1 reset spacing", d, 10);

        // R2 / R10
        wr(UNL, 8'h5A);
        rd(UNL, d); check("R2 unlock reads zero", d, 0);
        wr(STA, 8'h01);  // consume unlock harmlessly
        rd(32'hFFFF_F900, d); check("R10 unmapped read", d, 0);
        @(negedge clk); #1 check("R10 rd_en low", int'(rdata), 0);

        // R4 guarded write without unlock
        wr(RAT, 8'h03);
        rd(RAT, d); check("R4 ratio unchanged", d, 0);
        rd(STA, d); check("R4 error set", d, 1);
        wr(FLS, 8'h77);
        rd(FLS, d); check("R4 flash unchanged", d, 0);

        // R6 sticky error
        wr(STA, 8'hFF);
        rd(STA, d); check("R6 write 1 keeps error", d, 1);
        wr(STA, 8'hFE);
        rd(STA, d); check("R6 write 0 clears error", d, 0);

        // R3 legal sequence
        wr(UNL, 8'h00); wr(RAT, 8'hFE);
        rd(RAT, d); check("R3 ratio stored", d, 2);
        rd(STA, d); check("R3 no error", d, 0);
        repeat (25) @(negedge clk);
        check("R3 ratio applied", int'(ratio_active), 2);

        // R5 unlock consumed by unrelated write
        wr(UNL, 8'h11); wr(STA, 8'h01); wr(RAT, 8'h01);
        rd(RAT, d); check("R5 ratio unchanged", d, 2);
        rd(STA, d); check("R5 error set", d, 1);
        wr(STA, 8'h00);
        wr(UNL, 8'h22); wr(UNL, 8'h33); wr(RAT, 8'h01);
        rd(RAT, d); check("R5 re-arm accepted", d, 1);
        rd(STA, d); check("R5 re-arm no error", d, 0);

        // R9 flash register
        wr(UNL, 8'hAA); wr(FLS, 8'hA5);
        rd(FLS, d); check("R9 flash stored", d, 8'hA5);
        check("R9 flash output", int'(flash_mode), 8'hA5);
        wr(FLS, 8'h3C);
        rd(FLS, d); check("R9 flash locked", d, 8'hA5);
        wr(STA, 8'h00);

        // R7 / R8 sweep of every transition
        for (int f = 0; f < 4; f++)
            for (int t = 0; t < 4; t++)
                transition(f, t);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule